// File: doc/BRIEF.md
# Packed Block Transfer Engine

This block moves a run of data between a 16-bit word-addressed local memory and an 8-bit byte-addressed external memory, or compares the two regions without changing either. One command supplies the starting local word address, an external page number, a starting byte address inside that page, an operation, a data format and a count. The engine then steps through both memories one access per cycle, using whichever byte ordering the format calls for.

Four formats are available. The nybble format unpacks each local word into four external bytes and can only be used for writes. The byte format pairs each external byte with the low half of one local word. The two word formats pair each external byte pair with one local word, either in straight byte order or in swapped order. A compare walks from the last element back to the first. It stops at the first difference it finds and returns how many elements were still left, so zero means the regions match. Both memories sit outside the block and behave as synchronous single-port RAMs with one cycle of read latency.

Top module: `blk_xfer_engine`

## Requirements
- R1: With op code 0 (read) and format code 1 (byte), element i takes external byte (start+i) and writes it to local word (base+i) as {8'h00, byte}. The count gives the number of bytes.
- R2: In format code 2 (straight word), element i covers external bytes start+2i and start+2i+1. The first of these is the high half of local word base+i and the second is the low half. Format code 3 (swapped word) reverses the two halves. Both formats work for read (op 0) and write (op 1), and the count is in words.
- R3: With op code 1 (write) and format code 1 (byte), the low half of local word base+i goes to external byte start+i. The high half of the local word has no effect on anything written.
- R4: With op code 1 and format code 0 (nybble), local word base+i fills external bytes start+4i to start+4i+3. Bits [15:12] go to the lowest address and bits [3:0] to the highest. Each byte holds its nybble in bits [3:0] and zero in bits [7:4], and the count is in local words.
- R5: Op code 2 (compare) is valid in formats 1, 2 and 3. It checks elements from index count-1 down to 0, pairing them exactly as a read would. In byte format only the low half of the local word is compared. The result is k+1, where k is the highest index that differs, or 0 if every element matches. A compare writes neither memory.
- R6: The external address is {page, a}, where a is a 16-bit byte address that advances modulo 2^16. The page field never changes during a command. Local addresses advance modulo 2^LAW.
- R7: Op code 3, and any op other than write in format 0, completes without any memory access and returns result 0.
- R8: A start is accepted only while busy is low. Busy is high from the cycle after acceptance through the one-cycle done pulse, and it is low in the cycle after done. A start while busy is high, including in the done cycle, is ignored. The result holds until the next accepted start.
- R9: A count of zero raises done in the cycle after acceptance, with result 0 and no memory access.
- R10: In any cycle at most one of the two memories is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 2 | 0 read, 1 write, 2 compare, 3 reserved |
| cmd_fmt | input | 2 | 0 nybble, 1 byte, 2 straight word, 3 swapped word |
| cmd_loc_addr | input | LAW | Starting local word address |
| cmd_page | input | PW | External page number |
| cmd_ext_addr | input | 16 | Starting external byte address within the page |
| cmd_count | input | CW | Element count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | CW | Remaining count from a compare, otherwise 0 |
| loc_en | output | 1 | Local memory access enable |
| loc_we | output | 1 | Local memory write enable |
| loc_addr | output | LAW | Local word address |
| loc_wdata | output | 16 | Local write data |
| loc_rdata | input | 16 | Local read data, one cycle after the read |
| ext_en | output | 1 | External memory access enable |
| ext_we | output | 1 | External memory write enable |
| ext_addr | output | PW+16 | External byte address {page, byte address} |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, one cycle after the read |

## Verification
Two events can fall in the same cycle. The first case is a new start strobe that arrives while a transfer is running or exactly in its done cycle. The bench provokes it by driving a conflicting write command at both points. It then requires that neither memory shows any trace of that command and that busy drops right after done. The second case is a compare mismatch on element 0, the last element examined. This happens in the same step where the scan would otherwise finish, so the bench corrupts element 0 and expects a result of 1 rather than 0. It also corrupts both ends of the region to confirm that the highest index is the one reported.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CMP   = 2'd2,
        OP_RSVD  = 2'd3
    } blkx_op_e;

    typedef enum logic [1:0] {
        FMT_NYB  = 2'd0,
        FMT_BYTE = 2'd1,
        FMT_WSTR = 2'd2,
        FMT_WSWP = 2'd3
    } blkx_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LRD  = 3'd1,
        ST_LCAP = 3'd2,
        ST_EWR  = 3'd3,
        ST_ERD  = 3'd4,
        ST_ECAP = 3'd5,
        ST_LWR  = 3'd6,
        ST_DONE = 3'd7
    } blkx_st_e;

    // index of the last external byte lane of one element
    function automatic logic [1:0] last_lane(input blkx_fmt_e f);
        case (f)
            FMT_NYB:  last_lane = 2'd3;
            FMT_BYTE: last_lane = 2'd0;
            default:  last_lane = 2'd1;
        endcase
    endfunction

    // log2 of the external bytes per element
    function automatic logic [1:0] elem_shift(input blkx_fmt_e f);
        case (f)
            FMT_NYB:  elem_shift = 2'd2;
            FMT_BYTE: elem_shift = 2'd0;
            default:  elem_shift = 2'd1;
        endcase
    endfunction

    function automatic logic cmd_legal(input blkx_op_e op, input blkx_fmt_e f);
        cmd_legal = (op != OP_RSVD) && ((f != FMT_NYB) || (op == OP_WRITE));
    endfunction

endpackage

// File: rtl/blkx_addr_gen.sv
module blkx_addr_gen
    import blkx_pkg::*;
#(
    parameter int LAW = 10,
    parameter int PW  = 4
) (
    input  logic [LAW-1:0]   loc_base,
    input  logic [PW-1:0]    page,
    input  logic [15:0]      ext_base,
    input  logic [LAW-1:0]   idx_loc,
    input  logic [15:0]      idx_ext,
    input  logic [1:0]       lane,
    input  logic [1:0]       shift,
    output logic [LAW-1:0]   loc_addr,
    output logic [PW+15:0]   ext_addr
);
    logic [15:0] offs;
    logic [15:0] byte_addr;

    always_comb begin
        offs      = (idx_ext << shift) + {14'd0, lane};
        byte_addr = ext_base + offs;   // wraps inside the page
        loc_addr  = loc_base + idx_loc;
        ext_addr  = {page, byte_addr};
    end
endmodule

// File: rtl/blkx_lane.sv
module blkx_lane
    import blkx_pkg::*;
(
    input  blkx_fmt_e   fmt,
    input  logic [1:0]  lane,
    input  logic [15:0] loc_word,
    input  logic [7:0]  first_byte,
    input  logic [7:0]  cur_byte,
    output logic [7:0]  out_byte,
    output logic [15:0] in_word,
    output logic        match
);
    always_comb begin
        case (fmt)
            FMT_NYB: begin
                case (lane)
                    2'd0:    out_byte = {4'h0, loc_word[15:12]};
                    2'd1:    out_byte = {4'h0, loc_word[11:8]};
                    2'd2:    out_byte = {4'h0, loc_word[7:4]};
                    default: out_byte = {4'h0, loc_word[3:0]};
                endcase
                in_word = {8'h00, cur_byte};
            end
            FMT_BYTE: begin
                out_byte = loc_word[7:0];
                in_word  = {8'h00, cur_byte};
            end
            FMT_WSTR: begin
                out_byte = lane[0] ? loc_word[7:0] : loc_word[15:8];
                in_word  = {first_byte, cur_byte};
            end
            default: begin
                out_byte = lane[0] ? loc_word[15:8] : loc_word[7:0];
                in_word  = {cur_byte, first_byte};
            end
        endcase
        if (fmt == FMT_BYTE) match = (in_word[7:0] == loc_word[7:0]);
        else                 match = (in_word == loc_word);
    end
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
    import blkx_pkg::*;
#(
    parameter int LAW = 10,
    parameter int PW  = 4,
    parameter int CW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      cmd_op,
    input  logic [1:0]      cmd_fmt,
    input  logic [LAW-1:0]  cmd_loc_addr,
    input  logic [PW-1:0]   cmd_page,
    input  logic [15:0]     cmd_ext_addr,
    input  logic [CW-1:0]   cmd_count,
    output logic            busy,
    output logic            done,
    output logic [CW-1:0]   result,
    output logic            loc_en,
    output logic            loc_we,
    output logic [LAW-1:0]  loc_addr,
    output logic [15:0]     loc_wdata,
    input  logic [15:0]     loc_rdata,
    output logic            ext_en,
    output logic            ext_we,
    output logic [PW+15:0]  ext_addr,
    output logic [7:0]      ext_wdata,
    input  logic [7:0]      ext_rdata
);
    localparam logic [CW-1:0] ONE = 1;

    typedef struct packed {
        blkx_st_e        st;
        blkx_op_e        op;
        blkx_fmt_e       fmt;
        logic [LAW-1:0]  loc_base;
        logic [PW-1:0]   page;
        logic [15:0]     ext_base;
        logic [CW-1:0]   count;
        logic [CW-1:0]   idx;
        logic [1:0]      lane;
        logic [15:0]     word;
        logic [7:0]      first;
        logic [CW-1:0]   result;
    } eng_t;

    eng_t eng_q, eng_d;

    logic [LAW-1:0] idx_loc;
    logic [15:0]    idx_ext;
    logic [7:0]     lane_byte;
    logic [15:0]    lane_word;
    logic           lane_match;
    logic           step;
    logic           at_last_lane;
    logic           at_fwd_end;
    blkx_op_e       new_op;
    blkx_fmt_e      new_fmt;

    // element index narrowed or widened to each address space
    generate
        if (CW >= LAW) begin : g_loc_cut
            assign idx_loc = eng_q.idx[LAW-1:0];
        end else begin : g_loc_pad
            assign idx_loc = {{(LAW-CW){1'b0}}, eng_q.idx};
        end
        if (CW >= 16) begin : g_ext_cut
            assign idx_ext = eng_q.idx[15:0];
        end else begin : g_ext_pad
            assign idx_ext = {{(16-CW){1'b0}}, eng_q.idx};
        end
    endgenerate

    blkx_addr_gen #(.LAW(LAW), .PW(PW)) u_addr (
        .loc_base (eng_q.loc_base),
        .page     (eng_q.page),
        .ext_base (eng_q.ext_base),
        .idx_loc  (idx_loc),
        .idx_ext  (idx_ext),
        .lane     (eng_q.lane),
        .shift    (elem_shift(eng_q.fmt)),
        .loc_addr (loc_addr),
        .ext_addr (ext_addr)
    );

    blkx_lane u_lane (
        .fmt        (eng_q.fmt),
        .lane       (eng_q.lane),
        .loc_word   (eng_q.word),
        .first_byte (eng_q.first),
        .cur_byte   (ext_rdata),
        .out_byte   (lane_byte),
        .in_word    (lane_word),
        .match      (lane_match)
    );

    always_comb begin
        eng_d        = eng_q;
        loc_en       = 1'b0;
        loc_we       = 1'b0;
        loc_wdata    = eng_q.word;
        ext_en       = 1'b0;
        ext_we       = 1'b0;
        ext_wdata    = lane_byte;
        done         = 1'b0;
        step         = 1'b0;
        new_op       = blkx_op_e'(cmd_op);
        new_fmt      = blkx_fmt_e'(cmd_fmt);
        at_last_lane = (eng_q.lane == last_lane(eng_q.fmt));
        at_fwd_end   = (eng_q.idx == eng_q.count - ONE);

        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.op       = new_op;
                    eng_d.fmt      = new_fmt;
                    eng_d.loc_base = cmd_loc_addr;
                    eng_d.page     = cmd_page;
                    eng_d.ext_base = cmd_ext_addr;
                    eng_d.count    = cmd_count;
                    eng_d.lane     = 2'd0;
                    eng_d.result   = '0;
                    eng_d.idx      = (new_op == OP_CMP) ? cmd_count - ONE : '0;
                    if ((cmd_count == '0) || !cmd_legal(new_op, new_fmt))
                        eng_d.st = ST_DONE;
                    else if (new_op == OP_READ)
                        eng_d.st = ST_ERD;
                    else
                        eng_d.st = ST_LRD;
                end
            end
            ST_LRD: begin
                loc_en   = 1'b1;
                eng_d.st = ST_LCAP;
            end
            ST_LCAP: begin
                eng_d.word = loc_rdata;
                eng_d.lane = 2'd0;
                eng_d.st   = (eng_q.op == OP_WRITE) ? ST_EWR : ST_ERD;
            end
            ST_EWR: begin
                ext_en = 1'b1;
                ext_we = 1'b1;
                if (at_last_lane) step = 1'b1;
                else              eng_d.lane = eng_q.lane + 2'd1;
            end
            ST_ERD: begin
                ext_en   = 1'b1;
                eng_d.st = ST_ECAP;
            end
            ST_ECAP: begin
                if (!at_last_lane) begin
                    eng_d.first = ext_rdata;
                    eng_d.lane  = eng_q.lane + 2'd1;
                    eng_d.st    = ST_ERD;
                end else if (eng_q.op == OP_READ) begin
                    eng_d.word = lane_word;
                    eng_d.st   = ST_LWR;
                end else if (!lane_match) begin
                    eng_d.result = eng_q.idx + ONE;
                    eng_d.st     = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_LWR: begin
                loc_en = 1'b1;
                loc_we = 1'b1;
                step   = 1'b1;
            end
            default: begin
                done     = 1'b1;
                eng_d.st = ST_IDLE;
            end
        endcase

        // advance to the next element or finish
        if (step) begin
            eng_d.lane = 2'd0;
            if (eng_q.op == OP_CMP) begin
                if (eng_q.idx == '0) begin
                    eng_d.st = ST_DONE;
                end else begin
                    eng_d.idx = eng_q.idx - ONE;
                    eng_d.st  = ST_LRD;
                end
            end else if (at_fwd_end) begin
                eng_d.st = ST_DONE;
            end else begin
                eng_d.idx = eng_q.idx + ONE;
                eng_d.st  = (eng_q.op == OP_READ) ? ST_ERD : ST_LRD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy   = (eng_q.st != ST_IDLE);
    assign result = eng_q.result;

endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
    parameter int LAW = 10,
    parameter int PW  = 4,
    parameter int CW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      cmd_op,
    input logic [1:0]      cmd_fmt,
    input logic [PW-1:0]   cmd_page,
    input logic [CW-1:0]   cmd_count,
    input logic            busy,
    input logic            done,
    input logic            loc_en,
    input logic            loc_we,
    input logic [15:0]     loc_wdata,
    input logic            ext_en,
    input logic            ext_we,
    input logic [PW+15:0]  ext_addr,
    input logic [7:0]      ext_wdata
);
    logic [1:0]    op_r;
    logic [1:0]    fmt_r;
    logic [PW-1:0] page_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_r   <= 2'd0;
            fmt_r  <= 2'd0;
            page_r <= '0;
        end else if (start && !busy) begin
            op_r   <= cmd_op;
            fmt_r  <= cmd_fmt;
            page_r <= cmd_page;
        end
    end

    a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r9_zero_count_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cmd_count == '0)) |=> done);

    a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext_en) |-> (ext_addr[PW+15:16] == page_r));

    a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_en && ext_en));

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_r == 2'd2)) |-> !((loc_en && loc_we) || (ext_en && ext_we)));

    a_r1_read_no_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_r == 2'd0)) |-> !(ext_en && ext_we));

    a_r3_write_no_loc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_r == 2'd1)) |-> !(loc_en && loc_we));

    a_r1_byte_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_r == 2'd0) && (fmt_r == 2'd1) && loc_en && loc_we)
        |-> (loc_wdata[15:8] == 8'h00));

    a_r4_nybble_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (fmt_r == 2'd0) && ext_en && ext_we) |-> (ext_wdata[7:4] == 4'h0));

    a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ((op_r == 2'd3) || ((fmt_r == 2'd0) && (op_r != 2'd1))))
        |-> !(loc_en || ext_en));

endmodule

bind blk_xfer_engine blkx_chk #(.LAW(LAW), .PW(PW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_op    (cmd_op),
    .cmd_fmt   (cmd_fmt),
    .cmd_page  (cmd_page),
    .cmd_count (cmd_count),
    .busy      (busy),
    .done      (done),
    .loc_en    (loc_en),
    .loc_we    (loc_we),
    .loc_wdata (loc_wdata),
    .ext_en    (ext_en),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata)
);

// File: tb/blk_xfer_engine_tb.sv
`timescale 1ns/1ps
module blk_xfer_engine_tb;
    localparam int LAW = 10;
    localparam int PW  = 4;
    localparam int CW  = 16;
    localparam int LN  = 1 << LAW;
    localparam int EN  = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            start = 1'b0;
    logic [1:0]      cmd_op = '0;
    logic [1:0]      cmd_fmt = '0;
    logic [LAW-1:0]  cmd_loc_addr = '0;
    logic [PW-1:0]   cmd_page = '0;
    logic [15:0]     cmd_ext_addr = '0;
    logic [CW-1:0]   cmd_count = '0;
    logic            busy, done;
    logic [CW-1:0]   result;
    logic            loc_en, loc_we, ext_en, ext_we;
    logic [LAW-1:0]  loc_addr;
    logic [15:0]     loc_wdata, loc_rdata;
    logic [PW+15:0]  ext_addr;
    logic [7:0]      ext_wdata, ext_rdata;

    blk_xfer_engine #(.LAW(LAW), .PW(PW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_fmt(cmd_fmt),
        .cmd_loc_addr(cmd_loc_addr), .cmd_page(cmd_page), .cmd_ext_addr(cmd_ext_addr),
        .cmd_count(cmd_count), .busy(busy), .done(done), .result(result),
        .loc_en(loc_en), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .ext_en(ext_en), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    logic [15:0] lmem [LN];
    logic [7:0]  emem [EN];
    logic [15:0] exp_l [LN];
    logic [7:0]  exp_e [EN];

    int n_chk = 0;
    int n_fail = 0;
    int acc_cnt = 0;
    int overlap_cnt = 0;
    int cyc_total = 0;

    function automatic int eidx(input logic [PW-1:0] pg, input logic [15:0] a);
        return (int'(pg[1:0]) << 10) | (int'(a[15]) << 9) | int'(a[8:0]);
    endfunction

    // memory models: synchronous, one-cycle read latency
    always @(posedge clk) begin
        if (loc_en) begin
            if (loc_we) lmem[loc_addr] <= loc_wdata;
            loc_rdata <= lmem[loc_addr];
        end
        if (ext_en) begin
            if (ext_we) emem[eidx(ext_addr[PW+15:16], ext_addr[15:0])] <= ext_wdata;
            ext_rdata <= emem[eidx(ext_addr[PW+15:16], ext_addr[15:0])];
        end
        if (loc_en || ext_en) acc_cnt <= acc_cnt + 1;
        if (loc_en && ext_en) overlap_cnt <= overlap_cnt + 1;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cyc_total);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < LN; i++) begin
            lmem[i]  = 16'((i * 40503 + seed * 7919) ^ (i >> 3));
            exp_l[i] = lmem[i];
        end
        for (int i = 0; i < EN; i++) begin
            emem[i]  = 8'((i * 167 + seed * 61) ^ (i >> 4));
            exp_e[i] = emem[i];
        end
    endtask

    task automatic check_mems(input string req);
        int bad_l = -1;
        int bad_e = -1;
        for (int i = 0; i < LN; i++) if (bad_l < 0 && lmem[i] !== exp_l[i]) bad_l = i;
        for (int i = 0; i < EN; i++) if (bad_e < 0 && emem[i] !== exp_e[i]) bad_e = i;
        if (bad_l < 0) chk(1'b1, req, "local", 0, 0);
        else chk(1'b0, req, $sformatf("local word %0d", bad_l), lmem[bad_l], exp_l[bad_l]);
        if (bad_e < 0) chk(1'b1, req, "external", 0, 0);
        else chk(1'b0, req, $sformatf("external byte %0d", bad_e), emem[bad_e], exp_e[bad_e]);
    endtask

    function automatic int bpe(input logic [1:0] fmt);
        return (fmt == 2'd0) ? 4 : (fmt == 2'd1) ? 1 : 2;
    endfunction

    // reference model computed from the requirements
    task automatic ref_apply(input logic [1:0] op, input logic [1:0] fmt,
                             input logic [LAW-1:0] lb, input logic [PW-1:0] pg,
                             input logic [15:0] eb, input int cnt, output int res);
        int n;
        logic [15:0] w, e;
        res = 0;
        if (op == 2'd3 || (fmt == 2'd0 && op != 2'd1)) return;
        n = bpe(fmt);
        if (op == 2'd0) begin
            for (int i = 0; i < cnt; i++) begin
                int la = (int'(lb) + i) % LN;
                logic [7:0] b0 = exp_e[eidx(pg, 16'(int'(eb) + i * n))];
                logic [7:0] b1 = exp_e[eidx(pg, 16'(int'(eb) + i * n + 1))];
                if (fmt == 2'd1)      exp_l[la] = {8'h00, b0};
                else if (fmt == 2'd2) exp_l[la] = {b0, b1};
                else                  exp_l[la] = {b1, b0};
            end
        end else if (op == 2'd1) begin
            for (int i = 0; i < cnt; i++) begin
                w = exp_l[(int'(lb) + i) % LN];
                for (int k = 0; k < n; k++) begin
                    int ei = eidx(pg, 16'(int'(eb) + i * n + k));
                    if (fmt == 2'd0)      exp_e[ei] = 8'((w >> (12 - 4 * k)) & 16'hF);
                    else if (fmt == 2'd1) exp_e[ei] = w[7:0];
                    else if (fmt == 2'd2) exp_e[ei] = (k == 0) ? w[15:8] : w[7:0];
                    else                  exp_e[ei] = (k == 0) ? w[7:0] : w[15:8];
                end
            end
        end else begin
            for (int i = cnt - 1; i >= 0; i--) begin
                logic [7:0] b0 = exp_e[eidx(pg, 16'(int'(eb) + i * n))];
                logic [7:0] b1 = exp_e[eidx(pg, 16'(int'(eb) + i * n + 1))];
                w = exp_l[(int'(lb) + i) % LN];
                e = (fmt == 2'd1) ? {8'h00, b0} : (fmt == 2'd2) ? {b0, b1} : {b1, b0};
                if ((fmt == 2'd1) ? (w[7:0] != e[7:0]) : (w != e)) begin
                    res = i + 1;
                    break;
                end
            end
        end
    endtask

    // make the local region equal to the external one, then corrupt some elements
    task automatic prep_cmp(input logic [1:0] fmt, input logic [LAW-1:0] lb,
                            input logic [PW-1:0] pg, input logic [15:0] eb,
                            input int cnt, input int variant);
        int n = bpe(fmt);
        for (int i = 0; i < cnt; i++) begin
            int la = (int'(lb) + i) % LN;
            logic [7:0] b0 = emem[eidx(pg, 16'(int'(eb) + i * n))];
            logic [7:0] b1 = emem[eidx(pg, 16'(int'(eb) + i * n + 1))];
            if (fmt == 2'd1)      lmem[la] = {lmem[la][15:8] ^ 8'h5A, b0};
            else if (fmt == 2'd2) lmem[la] = {b0, b1};
            else                  lmem[la] = {b1, b0};
        end
        if (variant >= 1) lmem[int'(lb) % LN] ^= 16'h0001;
        if (variant == 2 && cnt > 1) lmem[(int'(lb) + cnt - 1) % LN] ^= 16'h0010;
        for (int i = 0; i < LN; i++) exp_l[i] = lmem[i];
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [1:0] fmt,
                           input logic [LAW-1:0] lb, input logic [PW-1:0] pg,
                           input logic [15:0] eb, input int cnt, input bit poke,
                           input string req, output logic [CW-1:0] res,
                           output int cyc, output int acc);
        int acc0;
        @(negedge clk);
        acc0 = acc_cnt;
        start = 1'b1; cmd_op = op; cmd_fmt = fmt; cmd_loc_addr = lb;
        cmd_page = pg; cmd_ext_addr = eb; cmd_count = CW'(cnt);
        @(negedge clk);
        if (poke) begin
            start = 1'b1; cmd_op = 2'd1; cmd_fmt = 2'd1; cmd_loc_addr = 10'd5;
            cmd_page = 4'd1; cmd_ext_addr = 16'h0080; cmd_count = 16'd3;
        end else begin
            start = 1'b0;
        end
        chk(busy === 1'b1, "R8", "busy after start", busy, 1);
        cyc = 1;
        while (done !== 1'b1 && cyc < 4000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(done === 1'b1, req, "done reached", done, 1);
        res = result;
        if (poke) begin
            start = 1'b1; cmd_op = 2'd1; cmd_fmt = 2'd1; cmd_count = 16'd3;
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R8", "idle after done", {busy, done}, 0);
        chk(result === res, "R8", "result held", result, res);
        acc = acc_cnt - acc0;
    endtask

    task automatic do_case(input logic [1:0] op, input logic [1:0] fmt,
                           input logic [LAW-1:0] lb, input logic [PW-1:0] pg,
                           input logic [15:0] eb, input int cnt, input int variant,
                           input bit poke, input string req);
        int exp_res, cyc, acc;
        logic [CW-1:0] res;
        fill(int'(lb) + cnt * 13 + variant);
        if (op == 2'd2) prep_cmp(fmt, lb, pg, eb, cnt, variant);
        ref_apply(op, fmt, lb, pg, eb, cnt, exp_res);
        run_cmd(op, fmt, lb, pg, eb, cnt, poke, req, res, cyc, acc);
        chk(res == CW'(exp_res), req, "result", res, exp_res);
        check_mems(req);
    endtask

    initial begin
        int cnts [3] = '{1, 3, 16};
        int cyc, acc;
        logic [CW-1:0] res;

        fill(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R8", "reset busy/done", {busy, done}, 0);
        chk(loc_en === 1'b0 && ext_en === 1'b0, "R8", "reset no access", {loc_en, ext_en}, 0);

        // read sweep: byte R1, words R2
        for (int f = 1; f < 4; f++)
            for (int c = 0; c < 3; c++)
                do_case(2'd0, 2'(f), 10'(100 + f * 40), 4'd1, 16'(32 + f * 8), cnts[c], 0, 0,
                        (f == 1) ? "R1" : "R2");
        // write sweep: nybble R4, byte R3, words R2
        for (int f = 0; f < 4; f++)
            for (int c = 0; c < 3; c++)
                do_case(2'd1, 2'(f), 10'(300 + f * 40), 4'd1, 16'(16 + f * 8), cnts[c], 0, 0,
                        (f == 0) ? "R4" : (f == 1) ? "R3" : "R2");
        // compare sweep R5: all match, mismatch at element 0, mismatch at both ends
        for (int f = 1; f < 4; f++)
            for (int c = 0; c < 3; c++)
                for (int v = 0; v < 3; v++)
                    do_case(2'd2, 2'(f), 10'(500 + f * 30), 4'd1, 16'(64 + f * 4), cnts[c], v, 0, "R5");

        // R6: byte address wraps inside the page, page stays; local address wraps
        do_case(2'd0, 2'd2, 10'd200, 4'd2, 16'hFFFD, 4, 0, 0, "R6");
        do_case(2'd1, 2'd3, 10'd210, 4'd2, 16'hFFFD, 4, 0, 0, "R6");
        do_case(2'd1, 2'd0, 10'd220, 4'd2, 16'hFFFE, 2, 0, 0, "R6");
        do_case(2'd2, 2'd2, 10'd230, 4'd2, 16'hFFFF, 3, 1, 0, "R6");
        do_case(2'd0, 2'd1, 10'd1022, 4'd1, 16'h0040, 4, 0, 0, "R6");

        // R7: illegal combinations do nothing
        fill(77);
        run_cmd(2'd3, 2'd1, 10'd10, 4'd1, 16'h0010, 5, 0, "R7", res, cyc, acc);
        chk(res == 0 && acc == 0, "R7", "reserved op result/accesses", {res, 16'(acc)}, 0);
        run_cmd(2'd0, 2'd0, 10'd10, 4'd1, 16'h0010, 5, 0, "R7", res, cyc, acc);
        chk(res == 0 && acc == 0, "R7", "nybble read result/accesses", {res, 16'(acc)}, 0);
        run_cmd(2'd2, 2'd0, 10'd10, 4'd1, 16'h0010, 5, 0, "R7", res, cyc, acc);
        chk(res == 0 && acc == 0, "R7", "nybble compare result/accesses", {res, 16'(acc)}, 0);
        check_mems("R7");

        // R9: zero count
        run_cmd(2'd0, 2'd1, 10'd10, 4'd1, 16'h0010, 0, 0, "R9", res, cyc, acc);
        chk(cyc == 1, "R9", "done latency", cyc, 1);
        chk(res == 0 && acc == 0, "R9", "result/accesses", {res, 16'(acc)}, 0);
        check_mems("R9");

        // R8: start while busy and on the done cycle is ignored
        do_case(2'd0, 2'd2, 10'd400, 4'd1, 16'h0100, 5, 0, 1, "R8");
        do_case(2'd2, 2'd3, 10'd420, 4'd1, 16'h0110, 4, 1, 1, "R8");

        // R10: no cycle touched both memories
        chk(overlap_cnt == 0, "R10", "cycles with both sides active", overlap_cnt, 0);

        finish_run();
    end
endmodule